// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block sits between a memory bus controller and a pseudo-SRAM. It walks the memory through its power-up sequence and owns the memory's chip enable and sleep pin until the memory is usable. During that time it stalls the controller. The power-up sequence is a long settle time with chip enable held high, followed by a fixed number of throw-away read cycles. After that it passes the controller's strobes straight to the memory and tracks whether the memory is idle in standby or busy with an access.

The host can put the memory into deep power-down and take it out again. A sleep request is held until the controller has finished its current access. Chip enable is then forced high, and the sleep pin is pulled low one cycle later. Waking drives the sleep pin high again and takes the bus away for another full settle time. Because deep power-down loses the array contents, a sticky flag reports this until the host acknowledges it. All delays are given in microseconds and nanoseconds and are converted to cycles from a clock-period parameter.

Top module: `psram_pwr_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `state_o` is 0, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and `mem_zz_n` are 1, `bus_stall` is 1, and `ready` and `data_lost` are 0.
- R2: After reset is released, `state_o` stays 0 (settle) and `mem_ce_n` stays high for exactly WAIT_CYC = ceil(WAIT_US*1000/CLK_PERIOD_NS) cycles. `state_o` then becomes 1.
- R3: In state 1 the block issues NUM_READS read pulses. Each pulse holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for RD_CYC = ceil(READ_NS/CLK_PERIOD_NS) cycles and is followed by one cycle with both high. The state then becomes 2 (standby), so state 1 lasts NUM_READS*(RD_CYC+1) cycles.
- R4: `ready` is 1 only in state 2 (standby) and state 3 (active). `bus_stall` is always the inverse of `ready`.
- R5: In states 2 and 3 the memory strobes follow `ctl_ce_n`, `ctl_oe_n` and `ctl_we_n`. Standby goes to active in the cycle after `ctl_ce_n` is low. Active returns to standby in the cycle after `ctl_ce_n` is high and `bus_idle` is 1.
- R6: A pulse on `host_sleep_req` in any state other than 4 and 5 is remembered. The block moves to state 4 (deep power-down) only from standby and only when `bus_idle` is 1. A request made during an access or during power-up is therefore carried out later.
- R7: `mem_zz_n` falls only in a cycle where `mem_ce_n` is high and was already high in the previous cycle. In the first cycle of state 4 it is still 1, and from the second cycle on it is 0.
- R8: In states 0, 4 and 5, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are held at 1 whatever the controller drives.
- R9: `host_wake_req` in state 4 moves the block to state 5 with `mem_zz_n` at 1. State 5 lasts WAIT_CYC cycles and is followed directly by state 2 with no read pulses. `host_wake_req` has no effect in any other state.
- R10: `data_lost` becomes 1 in the cycle the block enters state 4 and stays 1 until a cycle with `host_lost_ack` high has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sleep_req | input | 1 | Pulse asking for deep power-down |
| host_wake_req | input | 1 | Pulse asking to leave deep power-down |
| host_lost_ack | input | 1 | Clears the contents-lost flag |
| ctl_ce_n | input | 1 | Controller chip enable, active low |
| ctl_oe_n | input | 1 | Controller output enable, active low |
| ctl_we_n | input | 1 | Controller write enable, active low |
| bus_idle | input | 1 | Controller has no access in progress |
| mem_ce_n | output | 1 | Chip enable to the memory |
| mem_oe_n | output | 1 | Output enable to the memory |
| mem_we_n | output | 1 | Write enable to the memory |
| mem_zz_n | output | 1 | Sleep pin to the memory, low = deep power-down |
| bus_stall | output | 1 | Controller must not start an access |
| ready | output | 1 | Memory usable (standby or active) |
| data_lost | output | 1 | Array contents lost through deep power-down |
| state_o | output | 3 | Current power state code |

## Verification
Every state change is registered once. The memory strobes, `ready` and `bus_stall` are decoded from the state without further delay, so each result is due one clock edge after the inputs that cause it. The only exception is the sleep pin, which falls one edge later than the entry into deep power-down. Inputs are changed on the falling edge and outputs are sampled on the next falling edge, which lets one edge act between stimulus and check. The two long waits and the read burst are measured by counting falling edges until `state_o` changes and comparing the count with WAIT_CYC or NUM_READS*(RD_CYC+1).

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

    typedef enum logic [2:0] {
        PS_SETTLE     = 3'd0,
        PS_DUMMY_RD   = 3'd1,
        PS_STANDBY    = 3'd2,
        PS_ACTIVE     = 3'd3,
        PS_DEEP_SLEEP = 3'd4,
        PS_WAKE_WAIT  = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic zz_n;
    } mem_pins_t;

    localparam mem_pins_t PINS_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, zz_n: 1'b1};

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic logic owns_bus(input pwr_state_e s);
        return (s == PS_STANDBY) || (s == PS_ACTIVE);
    endfunction

endpackage

// File: rtl/psram_us_timer.sv
module psram_us_timer #(
    parameter int unsigned LIMIT = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/psram_init_reader.sv
module psram_init_reader #(
    parameter int unsigned RD_CYC = 14,
    parameter int unsigned NUM_RD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic rd_active,
    output logic done
);
    localparam int unsigned PW = $clog2(RD_CYC + 1);
    localparam int unsigned NW = (NUM_RD > 1) ? $clog2(NUM_RD) : 1;
    localparam logic [PW-1:0] GAP_PHASE = PW'(RD_CYC);
    localparam logic [NW-1:0] LAST_RD   = NW'(NUM_RD - 1);

    logic [PW-1:0] phase;
    logic [NW-1:0] rd_cnt;
    logic          in_gap;

    assign in_gap    = (phase == GAP_PHASE);
    assign rd_active = run && !in_gap;
    assign done      = run && in_gap && (rd_cnt == LAST_RD);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase  <= '0;
            rd_cnt <= '0;
        end else if (in_gap) begin
            phase  <= '0;
            rd_cnt <= rd_cnt + 1'b1;
        end else begin
            phase  <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
    import psram_pwr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned WAIT_US       = 200,
    parameter int unsigned READ_NS       = 70,
    parameter int unsigned NUM_READS     = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_sleep_req,
    input  logic       host_wake_req,
    input  logic       host_lost_ack,
    input  logic       ctl_ce_n,
    input  logic       ctl_oe_n,
    input  logic       ctl_we_n,
    input  logic       bus_idle,
    output logic       mem_ce_n,
    output logic       mem_oe_n,
    output logic       mem_we_n,
    output logic       mem_zz_n,
    output logic       bus_stall,
    output logic       ready,
    output logic       data_lost,
    output logic [2:0] state_o
);
    localparam int unsigned WAIT_CYC = ceil_div(WAIT_US * 1000, CLK_PERIOD_NS);
    localparam int unsigned RD_CYC   = (ceil_div(READ_NS, CLK_PERIOD_NS) > 0) ?
                                       ceil_div(READ_NS, CLK_PERIOD_NS) : 1;

    pwr_state_e state, nxt;
    logic       sleep_pend;
    logic       zz_arm;
    logic       t_run, t_done;
    logic       r_run, r_active, r_done;
    logic       dpd_enter;
    mem_pins_t  pins;

    assign t_run = (state == PS_SETTLE) || (state == PS_WAKE_WAIT);
    assign r_run = (state == PS_DUMMY_RD);

    psram_us_timer #(.LIMIT(WAIT_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (t_run),
        .done (t_done)
    );

    psram_init_reader #(.RD_CYC(RD_CYC), .NUM_RD(NUM_READS)) u_reader (
        .clk       (clk),
        .rst       (rst),
        .run       (r_run),
        .rd_active (r_active),
        .done      (r_done)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            PS_SETTLE:     if (t_done) nxt = PS_DUMMY_RD;
            PS_DUMMY_RD:   if (r_done) nxt = PS_STANDBY;
            PS_STANDBY: begin
                if (sleep_pend && bus_idle) nxt = PS_DEEP_SLEEP;
                else if (!ctl_ce_n)         nxt = PS_ACTIVE;
            end
            PS_ACTIVE:     if (ctl_ce_n && bus_idle) nxt = PS_STANDBY;
            PS_DEEP_SLEEP: if (host_wake_req) nxt = PS_WAKE_WAIT;
            PS_WAKE_WAIT:  if (t_done) nxt = PS_STANDBY;
            default:       nxt = PS_SETTLE;
        endcase
    end

    assign dpd_enter = (nxt == PS_DEEP_SLEEP) && (state != PS_DEEP_SLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PS_SETTLE;
            sleep_pend <= 1'b0;
            zz_arm     <= 1'b0;
        end else begin
            state  <= nxt;
            zz_arm <= (state == PS_DEEP_SLEEP) && (nxt == PS_DEEP_SLEEP);
            if (dpd_enter) begin
                sleep_pend <= 1'b0;
            end else if (host_sleep_req && (state != PS_DEEP_SLEEP) && (state != PS_WAKE_WAIT)) begin
                sleep_pend <= 1'b1;
            end
        end
    end

    psram_lost_flag u_lost (
        .clk    (clk),
        .rst    (rst),
        .set_i  (dpd_enter),
        .clr_i  (host_lost_ack),
        .flag_o (data_lost)
    );

    always_comb begin
        pins = PINS_QUIET;
        unique case (state)
            PS_DUMMY_RD: begin
                pins.ce_n = !r_active;
                pins.oe_n = !r_active;
            end
            PS_STANDBY, PS_ACTIVE: begin
                pins.ce_n = ctl_ce_n;
                pins.oe_n = ctl_oe_n;
                pins.we_n = ctl_we_n;
            end
            PS_DEEP_SLEEP: pins.zz_n = !zz_arm;
            default: pins = PINS_QUIET;
        endcase
    end

    assign mem_ce_n  = pins.ce_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_we_n  = pins.we_n;
    assign mem_zz_n  = pins.zz_n;
    assign ready     = owns_bus(state);
    assign bus_stall = !ready;
    assign state_o   = state;
endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_idle,
    input logic       mem_ce_n,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic       mem_zz_n,
    input logic       bus_stall,
    input logic       ready,
    input logic       data_lost,
    input logic [2:0] state_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state_o == 3'd0) && mem_ce_n && mem_zz_n && !data_lost);

    assert_stall_inverse_R4: assert property (@(posedge clk) disable iff (rst)
        bus_stall == !ready);

    assert_dpd_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd2 && $past(bus_idle)));

    assert_zz_after_ce_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_zz_n) |-> (mem_ce_n && $past(mem_ce_n)));

    assert_quiet_strobes_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 || state_o == 3'd4 || state_o == 3'd5) |-> (mem_ce_n && mem_oe_n && mem_we_n));

    assert_wake_pin_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd5) |-> mem_zz_n);

    assert_lost_on_entry_R10: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> data_lost);
endmodule

bind psram_pwr_seq psram_pwr_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_idle  (bus_idle),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_zz_n  (mem_zz_n),
    .bus_stall (bus_stall),
    .ready     (ready),
    .data_lost (data_lost),
    .state_o   (state_o)
);

// File: tb/psram_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_seq_tb_top;
    localparam int W  = 200;
    localparam int RD = 4;
    localparam int NR = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, wake_req = 1'b0, lost_ack = 1'b0;
    logic c_ce_n = 1'b1, c_oe_n = 1'b1, c_we_n = 1'b1, idle = 1'b1;
    logic m_ce_n, m_oe_n, m_we_n, m_zz_n, stall, rdy, lost;
    logic [2:0] st;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    psram_pwr_seq #(
        .CLK_PERIOD_NS(5), .WAIT_US(1), .READ_NS(20), .NUM_READS(NR)
    ) dut_i (
        .clk(clk), .rst(rst),
        .host_sleep_req(sleep_req), .host_wake_req(wake_req), .host_lost_ack(lost_ack),
        .ctl_ce_n(c_ce_n), .ctl_oe_n(c_oe_n), .ctl_we_n(c_we_n), .bus_idle(idle),
        .mem_ce_n(m_ce_n), .mem_oe_n(m_oe_n), .mem_we_n(m_we_n), .mem_zz_n(m_zz_n),
        .bus_stall(stall), .ready(rdy), .data_lost(lost), .state_o(st)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_reset_vals(input string tag);
        chk({tag, " R1 state"}, st, 0);
        chk({tag, " R1 strobes"}, {m_ce_n, m_oe_n, m_we_n, m_zz_n}, 4'b1111);
        chk({tag, " R1 stall/ready/lost"}, {stall, rdy, lost}, 3'b100);
    endtask

    // {sleep, wake, ack, ctl_ce_n, idle, exp_state[2:0], exp_ce_n, exp_zz_n, exp_ready, exp_lost}
    localparam logic [11:0] VEC [10] = '{
        12'b0_1_0_1_1_010_1_1_1_0,  // R9 wake ignored in standby
        12'b0_0_0_0_0_011_0_1_1_0,  // R5 standby -> active
        12'b1_0_0_0_0_011_0_1_1_0,  // R6 sleep during access deferred
        12'b0_0_0_0_0_011_0_1_1_0,  // R6 still active
        12'b0_0_0_1_1_010_1_1_1_0,  // R5 active -> standby
        12'b0_0_0_1_1_100_1_1_0_1,  // R6 R7 R10 enter deep sleep, pin still high
        12'b0_0_0_1_1_100_1_0_0_1,  // R7 pin falls
        12'b0_0_1_1_1_100_1_0_0_0,  // R10 ack clears flag
        12'b0_0_0_0_0_100_1_0_0_0,  // R8 controller ignored
        12'b0_1_0_1_1_101_1_1_0_0   // R9 wake
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int cyc, bad, lows, pulses, mism;
        logic prev;
        repeat (3) @(negedge clk);
        chk_reset_vals("reset");
        rst = 1'b0;

        // R2 settle length
        cyc = 0; bad = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (st == 3'd0 && m_ce_n !== 1'b1) bad++;
        end while (st == 3'd0 && cyc < 1000);
        chk("R2 settle cycles", cyc, W);
        chk("R2 ce high during settle", bad, 0);
        chk("R4 stall during settle", stall, 1);

        // R3 dummy reads
        cyc = 0; lows = 0; pulses = 0; mism = 0; prev = 1'b1;
        while (st == 3'd1 && cyc < 100) begin
            cyc++;
            if (!m_ce_n) lows++;
            if (!m_ce_n && prev) pulses++;
            if (m_ce_n != m_oe_n || !m_we_n) mism++;
            prev = m_ce_n;
            @(negedge clk);
        end
        chk("R3 read phase cycles", cyc, NR * (RD + 1));
        chk("R3 low cycles", lows, NR * RD);
        chk("R3 pulse count", pulses, NR);
        chk("R3 oe follows ce, we high", mism, 0);
        chk("R3 standby after reads", st, 2);
        chk("R4 ready in standby", {rdy, stall}, 2'b10);

        // table walk
        for (int i = 0; i < 10; i++) begin
            {sleep_req, wake_req, lost_ack, c_ce_n, idle} = VEC[i][11:7];
            @(negedge clk);
            chk($sformatf("row%0d R5/R6/R9 state", i), st, int'(VEC[i][6:4]));
            chk($sformatf("row%0d R7/R8 ce_n", i), m_ce_n, int'(VEC[i][3]));
            chk($sformatf("row%0d R7 zz_n", i), m_zz_n, int'(VEC[i][2]));
            chk($sformatf("row%0d R4 ready", i), rdy, int'(VEC[i][1]));
            chk($sformatf("row%0d R10 lost", i), lost, int'(VEC[i][0]));
        end
        {sleep_req, wake_req, lost_ack, c_ce_n, idle} = 5'b00011;

        // R9 wake wait length, no reads afterwards
        cyc = 0; bad = 0;
        while (st == 3'd5 && cyc < 1000) begin
            cyc++;
            if (!m_zz_n || !m_ce_n) bad++;
            @(negedge clk);
        end
        chk("R9 wake wait cycles", cyc, W);
        chk("R9 pins during wake wait", bad, 0);
        chk("R9 straight to standby", st, 2);

        // R6 sleep waits for idle, R5 pass-through
        sleep_req = 1'b1; idle = 1'b0;
        @(negedge clk);
        chk("R6 no sleep while busy", st, 2);
        sleep_req = 1'b0; c_ce_n = 1'b0; c_oe_n = 1'b0;
        @(negedge clk);
        chk("R5 active", st, 3);
        chk("R5 oe pass-through", m_oe_n, 0);
        c_ce_n = 1'b1; c_oe_n = 1'b1;
        @(negedge clk);
        chk("R5 stays active until idle", st, 3);
        idle = 1'b1;
        @(negedge clk);
        chk("R5 back to standby", st, 2);
        @(negedge clk);
        chk("R6 deferred sleep taken", st, 4);
        chk("R10 lost set", lost, 1);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        chk("R9 wake accepted", st, 5);

        // R1 mid-run reset, R6 sleep during settle
        rst = 1'b1;
        @(negedge clk);
        chk_reset_vals("midrun");
        rst = 1'b0; sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        cyc = 0;
        while (!rdy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
        chk("R6 ready after re-init", st, 2);
        @(negedge clk);
        chk("R6 sleep from settle honoured", st, 4);
        chk("R7 zz still high first cycle", m_zz_n, 1);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule